// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Majority Vote

This block converts the CAN receive line into one decided bit value per bit time. The raw receive input first passes through a two-flop synchroniser. An external bit-timing counter supplies two strobes. The pre-sample strobe marks each of the quanta just before the sample point, and the sample-point strobe marks the sample point itself. On the clock after the sample-point strobe, the block presents the decided bit together with a one-cycle valid pulse.

A mode bit selects one of two decisions. In single mode the decided bit is the synchronised line value at the sample point. In triple mode the decided bit is the majority of three samples: the sample-point value and the two most recent pre-samples. The mode bit sits in a small configuration register. A write to it is accepted only while the freeze input is high, and is dropped at all other times.

The control path is a two-state machine. In `ST_COLLECT` the block gathers pre-samples and waits. The transition `COLLECT->DECIDE` is taken on a sample-point strobe. In `ST_DECIDE` the decided bit is presented with valid high. From there the machine takes `DECIDE->DECIDE` if another sample-point strobe arrives, and `DECIDE->COLLECT` otherwise.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset the mode bit reads 0, bit_valid is 0, bit_out is 1, and both stored pre-samples hold recessive 1.
- R2: A change on rx_in becomes visible to sampling two clocks later, through a two-flop synchroniser that resets to 1.
- R3: With mode 0, bit_out takes the synchronised line value seen in the sample-point strobe cycle.
- R4: With mode 1, bit_out is the majority of the synchronised value at the sample point and the two stored pre-samples.
- R5: Each pre_strobe cycle stores the synchronised value as the newest pre-sample. The previous newest becomes the older one, and the older one is discarded.
- R6: bit_out updates, and bit_valid is high for exactly one cycle, on the clock edge after each sample-point strobe. Without a strobe, bit_valid is 0 and bit_out holds.
- R7: When cfg_wr is high with freeze high, the mode bit takes cfg_wdata on the next edge.
- R8: When cfg_wr is high with freeze low, the mode bit keeps its value.
- R9: When a mode write lands in the same cycle as a sample-point strobe, that decision uses the mode in force before the write.
- R10: Sample-point strobes on consecutive cycles give bit_valid high on consecutive cycles, each with its own decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Raw CAN receive line (1 = recessive) |
| pre_strobe | input | 1 | Pre-sample quantum strobe from the bit-timing counter |
| sp_strobe | input | 1 | Sample-point strobe from the bit-timing counter |
| freeze | input | 1 | Controller frozen; enables configuration writes |
| cfg_wr | input | 1 | Configuration write request |
| cfg_wdata | input | 1 | New mode value (0 single, 1 triple) |
| triple_mode | output | 1 | Current mode bit |
| bit_out | output | 1 | Decided bit value |
| bit_valid | output | 1 | One-cycle pulse marking a fresh decision |

## Verification
Two things can fall in the same cycle here: a frozen write to the mode bit and a sample-point decision. The same holds for a pre-sample store that coincides with a sample point. The bench drives cfg_wr together with sp_strobe while the stored samples disagree with the line, so the single-sample and majority outcomes differ. The reference model uses the mode and history as they stood before that edge, and the decided bit is compared with the model on the following cycle.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_DECIDE  = 1'b1
    } cbs_state_e;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_TRIPLE = 1'b1
    } cbs_mode_e;

    localparam logic RECESSIVE = 1'b1;

    // majority over an odd-sized vote vector
    function automatic logic vote_major(input logic [2:0] votes);
        return (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
    endfunction

endpackage

// File: rtl/cbs_rx_sync.sv
module cbs_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    import cbs_pkg::*;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RECESSIVE;
                    else        chain_q[g] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RECESSIVE;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cbs_sample_hist.sv
module cbs_sample_hist #(
    parameter int TAPS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            din,
    output logic [TAPS-1:0] taps
);
    import cbs_pkg::*;

    logic [TAPS-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= {TAPS{RECESSIVE}};
        else if (shift_en) hist_q <= {hist_q[TAPS-2:0], din};
    end

    assign taps = hist_q;

    // newest pre-sample lands in slot 0, older moves up
    assert_hist_newest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> taps[0] == $past(din));
    assert_hist_age_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> taps[1] == $past(taps[0]));
    assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps));

endmodule

// File: rtl/cbs_mode_reg.sv
module cbs_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic wr,
    input  logic wdata,
    output logic mode
);
    import cbs_pkg::*;

    cbs_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             mode_q <= MODE_SINGLE;
        else if (wr && freeze)  mode_q <= cbs_mode_e'(wdata);
    end

    assign mode = mode_q;

    assert_mode_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && freeze) |=> mode == $past(wdata));
    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> $stable(mode));

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_TAPS    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic pre_strobe,
    input  logic sp_strobe,
    input  logic freeze,
    input  logic cfg_wr,
    input  logic cfg_wdata,
    output logic triple_mode,
    output logic bit_out,
    output logic bit_valid
);
    import cbs_pkg::*;

    localparam int VOTES = PRE_TAPS + 1;

    logic                rx_s;
    logic [PRE_TAPS-1:0] pre_taps;
    logic                mode;
    logic [VOTES-1:0]    ballot;
    logic                decided;
    logic                bit_q;
    cbs_state_e          state_q, state_d;

    cbs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (rx_s)
    );

    cbs_sample_hist #(.TAPS(PRE_TAPS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pre_strobe),
        .din      (rx_s),
        .taps     (pre_taps)
    );

    cbs_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .freeze(freeze),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .mode  (mode)
    );

    assign ballot = {pre_taps, rx_s};

    always_comb begin
        if (mode == MODE_TRIPLE) decided = vote_major(ballot);
        else                     decided = rx_s;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (sp_strobe) state_d = ST_DECIDE;
            ST_DECIDE:  state_d = sp_strobe ? ST_DECIDE : ST_COLLECT;
            default:    state_d = ST_COLLECT;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bit_q <= RECESSIVE;
        else if (sp_strobe) bit_q <= decided;
    end

    always_comb begin
        bit_valid   = (state_q == ST_DECIDE);
        bit_out     = bit_q;
        triple_mode = mode;
    end

    assert_valid_follows_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_strobe |=> bit_valid);
    assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_strobe |=> (!bit_valid && $stable(bit_out)));
    assert_single_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_strobe && !triple_mode) |=> bit_out == $past(rx_s));
    assert_majority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_strobe && triple_mode && pre_taps[0] == pre_taps[1])
        |=> bit_out == $past(pre_taps[0]));

endmodule

// File: tb/tb_can_bit_sampler.sv
module tb_can_bit_sampler;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_in = 1'b1, pre_strobe = 1'b0, sp_strobe = 1'b0;
    logic freeze = 1'b0, cfg_wr = 1'b0, cfg_wdata = 1'b0;
    logic triple_mode, bit_out, bit_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    can_bit_sampler dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .pre_strobe(pre_strobe),
        .sp_strobe(sp_strobe), .freeze(freeze), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .triple_mode(triple_mode),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    // behavioural reference model
    int m_s1 = 1, m_s2 = 1, m_h_new = 1, m_h_old = 1, m_mode = 0;
    int m_bit = 1, m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_h_new = 1; m_h_old = 1;
            m_mode = 0; m_bit = 1; m_valid = 0;
        end else begin
            m_valid = sp_strobe ? 1 : 0;
            if (sp_strobe) begin
                if (m_mode == 1) m_bit = ((m_s2 + m_h_new + m_h_old) >= 2) ? 1 : 0;
                else             m_bit = m_s2;
            end
            if (pre_strobe) begin
                m_h_old = m_h_new;
                m_h_new = m_s2;
            end
            if (cfg_wr && freeze) m_mode = int'(cfg_wdata);
            m_s2 = m_s1;
            m_s1 = int'(rx_in);
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // drive inputs at a negedge, compare at the next negedge
    task automatic cyc(input string tag, input logic rx, input logic pre, input logic sp,
                       input logic frz, input logic wr, input logic wd);
        rx_in = rx; pre_strobe = pre; sp_strobe = sp;
        freeze = frz; cfg_wr = wr; cfg_wdata = wd;
        @(negedge clk);
        check(tag, "bit_out", int'(bit_out), m_bit);
        check(tag, "bit_valid", int'(bit_valid), m_valid);
        check(tag, "triple_mode", int'(triple_mode), m_mode);
    endtask

    // one bit time: pre strobes on the two quanta before the sample point
    task automatic bit_time(input string tag, input logic a, input logic b, input logic c);
        cyc(tag, a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(tag, b, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(tag, c, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(tag, c, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc(tag, c, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        checks++;
        if (bit_out !== 1'b1 || bit_valid !== 1'b0 || triple_mode !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b%b%b expected=100",
                     bit_out, bit_valid, triple_mode);
        end
        rst_n = 1'b1;

        // R1: recessive history seen by majority right after reset
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        cyc("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R1", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

        // R2: line change reaches sampling two clocks later
        cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8: write without freeze is dropped
        cyc("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R3: single-sample decisions
        for (int i = 0; i < 40; i++)
            bit_time("R3", 1'($urandom), 1'($urandom), 1'($urandom));

        // R7: enter triple mode while frozen
        cyc("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

        // R4/R5: majority, including a glitch at the sample point
        bit_time("R4", 1'b0, 1'b0, 1'b0);
        bit_time("R4", 1'b1, 1'b1, 1'b0);
        bit_time("R5", 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++)
            bit_time("R4", 1'($urandom), 1'($urandom), 1'($urandom));

        // R9: write coinciding with sample point, history disagrees with line
        cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R9", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        cyc("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        cyc("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: back-to-back sample points, with pre strobe overlap
        for (int i = 0; i < 30; i++)
            cyc("R10", 1'($urandom), 1'($urandom), 1'b1, 1'($urandom), 1'($urandom), 1'($urandom));
        cyc("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R6: mixed random traffic
        for (int i = 0; i < 200; i++)
            cyc("R6", 1'($urandom), 1'($urandom), 1'(($urandom % 3) == 0),
                1'($urandom), 1'($urandom), 1'($urandom));

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule